// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation vectors by a fixed weight matrix on a square grid of identical multiply-accumulate cells. A weight matrix is first shifted into the grid one row per load cycle. Each cell then holds its weight while activations travel rightwards along the rows and partial sums travel downwards along the columns. Every activation is used by all the cells of its row, so one input value feeds N multiplies.

An input skew delays row r of each vector by r cycles. Each cell therefore sees its activation in the same cycle as the partial sum from the cell above it. The cells form a diagonal wavefront and need no program of their own. An output deskew delays column c by N-1-c cycles. All N column sums of one vector therefore leave together under a single valid flag. The grid size is a parameter. It defaults to 4x4 for simulation, and the structure scales to 256x256.

Top module: `sysmm`

## Requirements
- R1: While `rst_n` is low, `y_valid` is 0 and `y` is all zeros.
- R2: Each cycle with `w_load` high shifts `w_in` into grid row 0 and moves every row down by one. After N load cycles, the vector given on load cycle k (counting from 0) sits in row N-1-k. Field c of `w_in`, at bits [c*AW +: AW], goes to column c. While `w_load` is low, the weights are held whatever `w_in` carries. `w_load` and `a_valid` are never high in the same cycle.
- R3: For an input vector x, where x[r] is `a_in[r*AW +: AW]`, output field c `y[c*SW +: SW]` equals the sum over r of x[r]*W[r][c], taken as a two's complement value. An all-zero vector gives all-zero sums.
- R4: The result of a vector sampled at a clock edge appears at the output with `y_valid` high after exactly 2N-2 further edges (6 for N=4), and it lasts one cycle.
- R5: Vectors may arrive on consecutive cycles. Each one produces its own result, and results come out in input order with no gaps added.
- R6: Activations and weights are signed AW-bit values. Products are sign-extended into SW-bit accumulators that wrap modulo 2^SW. The extreme inputs -128 and 127 give exact results.
- R7: `y_valid` is high only in the cycles that match an `a_valid` sample. Gaps in the input give gaps in the output at the same distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_load | input | 1 | Shift `w_in` into the weight grid this cycle |
| w_in | input | N*AW | One row of weights, column c in field c |
| a_valid | input | 1 | `a_in` carries a vector this cycle |
| a_in | input | N*AW | Activation vector, row r in field r |
| y_valid | output | 1 | `y` carries a finished result |
| y | output | N*SW | Column sums, column c in field c |

## Verification
A vector sampled at edge t has its result due after edge t+2N-2. The driver records that edge number with the expected sums when it pushes them into the scoreboard. The monitor samples on the falling edge, pops the oldest entry whenever `y_valid` is high, and checks both the value and the edge count. A `y_valid` with nothing queued, or entries left in the queue at the end, is reported against the streaming and gap requirements.

// File: rtl/sysmm.sv
module sysmm #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_load,
  input  logic [N*AW-1:0] w_in,
  input  logic          a_valid,
  input  logic [N*AW-1:0] a_in,
  output logic          y_valid,
  output logic [N*SW-1:0] y
);
  localparam int LAT = 2*N-2;

  logic signed [AW-1:0] wq  [N][N];
  logic signed [AW-1:0] act [N][N];
  logic signed [AW-1:0] sk  [N][N];
  logic signed [SW-1:0] ps  [N][N];
  logic signed [SW-1:0] dk  [N][N];
  logic signed [AW-1:0] rin [N];
  logic [LAT:0] vq;

  function automatic logic signed [SW-1:0] mac(input logic signed [SW-1:0] acc,
                                               input logic signed [AW-1:0] a,
                                               input logic signed [AW-1:0] w);
    logic signed [2*AW-1:0] p;
    p = a * w;
    return acc + SW'(p);
  endfunction

  always_comb
    for (int r = 0; r < N; r++)
      rin[r] = (r == 0) ? a_in[AW-1:0] : sk[r][(r == 0) ? 0 : r-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          wq[r][c]  <= '0;
          act[r][c] <= '0;
          sk[r][c]  <= '0;
          ps[r][c]  <= '0;
          dk[r][c]  <= '0;
        end
      vq <= '0;
    end else begin
      if (w_load)
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++)
            wq[r][c] <= (r == 0) ? w_in[c*AW +: AW] : wq[(r == 0) ? 0 : r-1][c];
      for (int r = 0; r < N; r++)
        for (int k = 0; k < N; k++)
          if (k < r)
            sk[r][k] <= (k == 0) ? a_in[r*AW +: AW] : sk[r][(k == 0) ? 0 : k-1];
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          act[r][c] <= (c == 0) ? rin[r] : act[r][(c == 0) ? 0 : c-1];
          ps[r][c]  <= mac((r == 0) ? '0 : ps[(r == 0) ? 0 : r-1][c],
                           (c == 0) ? rin[r] : act[r][(c == 0) ? 0 : c-1],
                           wq[r][c]);
        end
      for (int c = 0; c < N; c++)
        for (int k = 0; k < N; k++)
          if (k < N-1-c)
            dk[c][k] <= (k == 0) ? ps[N-1][c] : dk[c][(k == 0) ? 0 : k-1];
      vq <= {vq[LAT-1:0], a_valid};
    end
  end

  always_comb
    for (int c = 0; c < N; c++)
      y[c*SW +: SW] = (c == N-1) ? ps[N-1][c] : dk[c][(c == N-1) ? 0 : N-2-c];

  assign y_valid = vq[LAT];
endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int SW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            w_load,
  input logic            a_valid,
  input logic [N*AW-1:0] a_in,
  input logic            y_valid,
  input logic [N*SW-1:0] y
);
  localparam int LAT = 2*N-2;
  logic [LAT:0] pipe;
  int unsigned  zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
      zrun <= 0;
    end else begin
      pipe <= {pipe[LAT-1:0], a_valid};
      if (a_in != '0) zrun <= 0;
      else if (zrun <= LAT) zrun <= zrun + 1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!y_valid && y == '0));

  p_load_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_load && a_valid));

  p_zero_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zrun >= LAT + 1) |-> (y == '0));

  p_valid_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid == pipe[LAT]);
endmodule

bind sysmm sysmm_chk #(.N(N), .AW(AW), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .w_load(w_load), .a_valid(a_valid),
  .a_in(a_in), .y_valid(y_valid), .y(y));

// File: tb/sysmm_tb_top.sv
`timescale 1ns/1ps
module sysmm_tb_top;
  localparam int N = 4, AW = 8, SW = 32, LAT = 2*N-2;

  logic clk = 0, rst_n = 0, w_load = 0, a_valid = 0;
  logic [N*AW-1:0] w_in = '0, a_in = '0;
  logic y_valid;
  logic [N*SW-1:0] y;

  sysmm #(.N(N), .AW(AW), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_in(w_in),
    .a_valid(a_valid), .a_in(a_in), .y_valid(y_valid), .y(y));

  always #2 clk = ~clk;

  typedef struct { logic [N*SW-1:0] v; int t; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic signed [AW-1:0] W [N][N];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N*SW-1:0] got, input logic [N*SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [N*SW-1:0] model(input logic [N*AW-1:0] x);
    logic [N*SW-1:0] e;
    for (int c = 0; c < N; c++) begin
      int s = 0;
      for (int r = 0; r < N; r++) s += int'(signed'(x[r*AW +: AW])) * int'(W[r][c]);
      e[c*SW +: SW] = s;
    end
    return e;
  endfunction

  // load W: the row given on load cycle k ends in row N-1-k (R2)
  task automatic load_w();
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < N; c++) w_in[c*AW +: AW] = W[N-1-k][c];
      w_load = 1;
      @(negedge clk);
    end
    w_load = 0;
  endtask

  task automatic send(input logic [N*AW-1:0] x, input string req);
    exp_t e;
    a_in = x;
    a_valid = 1;
    e.v = model(x);
    e.t = cyc + 1 + LAT;
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    a_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [N*AW-1:0] rnd_vec();
    logic [N*AW-1:0] v;
    for (int r = 0; r < N; r++) v[r*AW +: AW] = AW'($urandom_range(0, 255));
    return v;
  endfunction

  task automatic rnd_w();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) W[r][c] = AW'($urandom_range(0, 255));
  endtask

  // scoreboard monitor: value (R3/R5/R6) and due cycle (R4), no spurious valid (R7)
  always @(negedge clk) begin
    if (rst_n && y_valid) begin
      if (q.size() == 0) begin
        check(0, "R7", "valid with no pending vector", y, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(y == e.v, e.req, "column sums", y, e.v);
        check(cyc == e.t, "R4", "result cycle", N*SW'(cyc), N*SW'(e.t));
      end
    end
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    check(!y_valid && y == '0, "R1", "reset state", {y_valid, y}, '0);
    rst_n = 1;
    idle(2);
    check(!y_valid && y == '0, "R1", "idle after reset", {y_valid, y}, '0);

    // identity weights
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) W[r][c] = (r == c) ? 8'sd1 : 8'sd0;
    load_w();
    send({8'd4, 8'd3, 8'd2, 8'd1}, "R3");
    send('0, "R3");
    idle(LAT + 2);

    // asymmetric weights prove row order of the load (R2)
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) W[r][c] = AW'(r * 16 + c + 1);
    load_w();
    // w_in toggles with w_load low: weights must hold (R2)
    for (int i = 0; i < 5; i++) begin w_in = $urandom; @(negedge clk); end
    send({8'd1, 8'd0, 8'd0, 8'd0}, "R2");
    send({8'd0, 8'd0, 8'd0, 8'd1}, "R2");
    send(rnd_vec(), "R2");
    idle(LAT + 2);

    // random weights, back-to-back stream
    rnd_w();
    load_w();
    for (int i = 0; i < 20; i++) send(rnd_vec(), "R5");
    // gapped stream
    for (int i = 0; i < 10; i++) begin
      send(rnd_vec(), "R7");
      idle(i % 3);
    end
    idle(LAT + 2);

    // signed extremes
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) W[r][c] = (c % 2 == 0) ? -8'sd128 : 8'sd127;
    load_w();
    send({N{8'h80}}, "R6");
    send({N{8'h7f}}, "R6");
    send({8'h80, 8'h7f, 8'h80, 8'h7f}, "R6");
    idle(LAT + 3);

    check(q.size() == 0, "R5", "results outstanding", N*SW'(q.size()), '0);
    finish_run();
  end
endmodule